// File: doc/BRIEF.md
# 4B/5B PCS Receive Decoder

This block sits behind the serial receive path of a 100 Mb/s twisted-pair physical layer. One line bit arrives per clock on `rxBit` after NRZI decoding and descrambling have already been done. While the line is idle it carries only ones. The block watches that stream for a break that looks like the start of a frame. It confirms the start-of-stream delimiter and uses that delimiter to lock the 5-bit code-group boundary. After that it turns each code group into a 4-bit nibble for the MAC side.

The two delimiter groups are reported as two preamble nibbles of value 0x5. Each nibble is presented with a one-cycle strobe. A data-valid level frames the whole reception. A frame ends cleanly on the end-of-stream pair. It ends with a receive-error pulse if the line returns to idle first or if a code group cannot be decoded. A break in the idle line that does not turn out to be a proper delimiter raises a false-carrier pulse instead.

Top module: `pcsRxTop`

## Requirements
- R1: While `rstN` is low and after it is released, `rxData`, `rxStb`, `rxDv`, `rxErr` and `falseCarrier` are all 0, and the bit history is treated as all ones.
- R2: An idle stream of ones produces no output. So does any break in it that holds only one zero, or only a single run of adjacent zeros. No strobe, no data-valid, no error and no false-carrier pulse result.
- R3: Carrier is examined on a 10-bit window. The window starts with two ones, then the first zero, and must contain a second zero that has at least one one between it and the first. If the window reads 11000 10001 (/J/ then /K/, earliest bit first), `rxDv` rises with `rxStb` high and `rxData` = 0x5 two cycles after the last /K/ bit is driven. A second 0x5 strobe follows in the next cycle.
- R4: If such a window differs from /J/K/, `falseCarrier` pulses for one cycle two cycles after the window's last bit. `rxDv` stays low, the bit history is reset to ones, and the search resumes.
- R5: After /J/K/, every 5 bits form one code group, with the first received bit as the MSB. Data groups decode as follows: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. Each decoded nibble appears with a one-cycle `rxStb` two cycles after the group's last bit.
- R6: /T/ (01101) followed by /R/ (00111) ends the frame without error. Neither group produces a strobe. `rxDv` falls two cycles after the last /R/ bit.
- R7: An idle group (11111) in place of a data or /T/ group ends the frame early. `rxErr` pulses for one cycle as `rxDv` falls, two cycles after the group's last bit.
- R8: Any other group ends the frame with the same `rxErr` pulse and `rxDv` fall. This covers codes that are neither data nor /T/, as well as /T/ followed by anything but /R/.
- R9: `rxDv` is high without a break from the first preamble strobe to the end of the frame. `rxStb` is never high while `rxDv` is low.
- R10: When a frame ends, the bit history is reset to ones. Leftover frame bits cannot start a carrier, and a new /J/K/ may follow at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Serial received bit |
| rxData | output | 4 | Decoded or preamble nibble |
| rxStb | output | 1 | One-cycle strobe marking a new nibble |
| rxDv | output | 1 | High for the whole received frame |
| rxErr | output | 1 | One-cycle pulse when a frame ends on idle or a bad code |
| falseCarrier | output | 1 | One-cycle pulse when a carrier break is not /J/K/ |

## Verification
Randomized frames carry random nibble counts and random payloads, and end in one of four ways: /T/R/, premature idle, an undecodable group, or /T/ followed by a data group. Comparing the strobe timing and the error pulse across these endings separates a clean end from an early one and a bad-code one. Directed streams with an isolated zero and a run of adjacent zeros show that noise which is not a carrier is ignored. Two non-/J/K/ windows, one of them a correct /J/ with a corrupted /K/, show false carrier apart from a real start. A frame launched with no idle gap after the previous /T/R/ shows that the history is cleared.

// File: rtl/pcsRxPkg.sv
package pcsRxPkg;

  localparam int CODE_W = 5;
  localparam int NIB_W  = 4;
  localparam int WIN_W  = 2 * CODE_W;

  // start-of-stream pair, earliest bit in the MSB
  localparam logic [WIN_W-1:0] SSD_PAIR = 10'b11000_10001;

  typedef enum logic [2:0] {
    GK_DATA,
    GK_T,
    GK_R,
    GK_IDLE,
    GK_BAD
  } groupKindT;

  typedef struct packed {
    logic emitPre;
    logic emitData;
    logic endFrame;
    logic raiseErr;
    logic raiseFalse;
    logic startCnt;
  } rxCmdT;

  typedef struct packed {
    logic      carrierHit;
    logic      ssdMatch;
    logic      groupReady;
    groupKindT kind;
  } rxStatT;

endpackage

// File: rtl/pcsRxDecode.sv
module pcsRxDecode
  import pcsRxPkg::*;
(
  input  logic [CODE_W-1:0] code,
  output groupKindT         kind,
  output logic [NIB_W-1:0]  nib
);

  always_comb begin
    kind = GK_DATA;
    nib  = '0;
    case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      5'b01101: kind = GK_T;
      5'b00111: kind = GK_R;
      5'b11111: kind = GK_IDLE;
      default:  kind = GK_BAD;
    endcase
  end

endmodule

// File: rtl/pcsRxPath.sv
module pcsRxPath
  import pcsRxPkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIBBLE = 4'h5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  rxCmdT            cmd,
  output rxStatT           stat,
  output logic [NIB_W-1:0] rxData,
  output logic             rxStb,
  output logic             rxDv,
  output logic             rxErr,
  output logic             falseCarrier
);

  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CODE_W - 1);

  logic [WIN_W-1:0] hist;
  logic [CNT_W-1:0] bitCnt;
  logic             seenOne;
  logic             laterZero;
  groupKindT        kindNow;
  logic [NIB_W-1:0] nibNow;

  // second zero separated from the first by at least one one
  always_comb begin
    seenOne   = 1'b0;
    laterZero = 1'b0;
    for (int i = WIN_W - 4; i >= 0; i--) begin
      if (hist[i]) seenOne = 1'b1;
      else if (seenOne) laterZero = 1'b1;
    end
  end

  pcsRxDecode u_decode (
    .code (hist[CODE_W-1:0]),
    .kind (kindNow),
    .nib  (nibNow)
  );

  always_comb begin
    stat.carrierHit = hist[WIN_W-1] & hist[WIN_W-2] & ~hist[WIN_W-3] & laterZero;
    stat.ssdMatch   = (hist == SSD_PAIR);
    stat.groupReady = (bitCnt == CNT_LAST);
    stat.kind       = kindNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist         <= '1;
      bitCnt       <= '0;
      rxData       <= '0;
      rxStb        <= 1'b0;
      rxDv         <= 1'b0;
      rxErr        <= 1'b0;
      falseCarrier <= 1'b0;
    end else begin
      if (cmd.endFrame || cmd.raiseFalse) hist <= {{(WIN_W-1){1'b1}}, rxBit};
      else                                hist <= {hist[WIN_W-2:0], rxBit};

      if (cmd.startCnt || bitCnt == CNT_LAST) bitCnt <= '0;
      else                                    bitCnt <= bitCnt + 1'b1;

      rxStb <= cmd.emitPre | cmd.emitData;
      if (cmd.emitPre)       rxData <= PRE_NIBBLE;
      else if (cmd.emitData) rxData <= nibNow;

      if (cmd.emitPre)       rxDv <= 1'b1;
      else if (cmd.endFrame) rxDv <= 1'b0;

      rxErr        <= cmd.raiseErr;
      falseCarrier <= cmd.raiseFalse;
    end
  end

  // R9
  stb_needs_dv_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxStb |-> rxDv);

  // R3
  pre_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDv) |-> (rxStb && rxData == PRE_NIBBLE));

  // R3
  pre_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDv) |=> (rxStb && rxDv && rxData == PRE_NIBBLE));

  // R4
  false_carrier_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    falseCarrier |-> (!rxDv && !$past(rxDv) && !rxErr));

  // R7
  err_ends_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> (!rxDv && $past(rxDv) && !rxStb));

endmodule

// File: rtl/pcsRxCtrl.sv
module pcsRxCtrl
  import pcsRxPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  rxStatT stat,
  output rxCmdT  cmd
);

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_PRE,
    ST_DATA,
    ST_TAIL
  } stateT;

  stateT state;
  stateT nextState;

  always_comb begin
    cmd       = '0;
    nextState = state;
    case (state)
      ST_HUNT: begin
        if (stat.carrierHit) begin
          if (stat.ssdMatch) begin
            cmd.emitPre  = 1'b1;
            cmd.startCnt = 1'b1;
            nextState    = ST_PRE;
          end else begin
            cmd.raiseFalse = 1'b1;
          end
        end
      end
      ST_PRE: begin
        cmd.emitPre = 1'b1;
        nextState   = ST_DATA;
      end
      ST_DATA: begin
        if (stat.groupReady) begin
          case (stat.kind)
            GK_DATA: cmd.emitData = 1'b1;
            GK_T:    nextState = ST_TAIL;
            default: begin
              cmd.raiseErr = 1'b1;
              cmd.endFrame = 1'b1;
              nextState    = ST_HUNT;
            end
          endcase
        end
      end
      ST_TAIL: begin
        if (stat.groupReady) begin
          cmd.endFrame = 1'b1;
          cmd.raiseErr = (stat.kind != GK_R);
          nextState    = ST_HUNT;
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= nextState;
  end

  // R6
  tail_after_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && stat.groupReady && stat.kind == GK_T) |=> (state == ST_TAIL));

  // R4
  hunt_stays_on_false_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.raiseFalse |=> (state == ST_HUNT));

endmodule

// File: rtl/pcsRxTop.sv
module pcsRxTop
  import pcsRxPkg::*;
#(
  parameter logic [3:0] PRE_NIBBLE = 4'h5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  output logic [3:0] rxData,
  output logic       rxStb,
  output logic       rxDv,
  output logic       rxErr,
  output logic       falseCarrier
);

  rxCmdT  cmd;
  rxStatT stat;

  pcsRxCtrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .cmd  (cmd)
  );

  pcsRxPath #(
    .PRE_NIBBLE (PRE_NIBBLE)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .rxBit        (rxBit),
    .cmd          (cmd),
    .stat         (stat),
    .rxData       (rxData),
    .rxStb        (rxStb),
    .rxDv         (rxDv),
    .rxErr        (rxErr),
    .falseCarrier (falseCarrier)
  );

endmodule

// File: tb/tb_pcsRxTop.sv
`timescale 1ns/1ps
module tb_pcsRxTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxBit = 1'b1;
  logic [3:0] rxData;
  logic       rxStb;
  logic       rxDv;
  logic       rxErr;
  logic       falseCarrier;

  always #5 clk = ~clk;

  pcsRxTop dut (
    .clk          (clk),
    .rstN         (rstN),
    .rxBit        (rxBit),
    .rxData       (rxData),
    .rxStb        (rxStb),
    .rxDv         (rxDv),
    .rxErr        (rxErr),
    .falseCarrier (falseCarrier)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lastCyc = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  int nLog, stbNoDv, errCnt, errCyc, fcCnt, riseCnt, fallCnt, fallCyc;
  bit prevDv;
  logic [3:0] logNib [64];
  int logCyc [64];
  logic [3:0] expNib [64];
  int expCyc [64];
  int nExp;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (monOn) begin
      if (rxStb) begin
        if (nLog < 64) begin
          logNib[nLog] = rxData;
          logCyc[nLog] = cyc;
        end
        nLog++;
        if (!rxDv) stbNoDv++;
      end
      if (rxErr) begin
        errCnt++;
        errCyc = cyc;
      end
      if (falseCarrier) fcCnt++;
      if (rxDv && !prevDv) riseCnt++;
      if (!rxDv && prevDv) begin
        fallCnt++;
        fallCyc = cyc;
      end
      prevDv = rxDv;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [4:0] enc5(logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic bit isKnown(logic [4:0] c);
    for (int i = 0; i < 16; i++) if (enc5(4'(i)) == c) return 1'b1;
    return (c == 5'b01101 || c == 5'b00111 || c == 5'b11111);
  endfunction

  task automatic sendBit(logic b);
    @(negedge clk);
    rxBit = b;
    lastCyc = cyc;
  endtask

  task automatic sendGroup(logic [4:0] g);
    for (int i = 4; i >= 0; i--) sendBit(g[i]);
  endtask

  task automatic sendIdle(int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic clearLog();
    @(posedge clk);
    #1;
    nLog = 0; stbNoDv = 0; errCnt = 0; errCyc = -1; fcCnt = 0;
    riseCnt = 0; fallCnt = 0; fallCyc = -1; nExp = 0;
  endtask

  task automatic pushExp(logic [3:0] n, int c);
    expNib[nExp] = n;
    expCyc[nExp] = c;
    nExp++;
  endtask

  // endKind: 0 = /T/R/, 1 = idle, 2 = bad code, 3 = /T/ then data
  task automatic runFrame(int nData, int endKind, int preIdle, int postIdle);
    int endCyc;
    bit expErr;
    string endReq;
    logic [3:0] n;
    logic [4:0] bad;
    clearLog();
    sendIdle(preIdle);
    sendGroup(5'b11000);
    sendGroup(5'b10001);
    pushExp(4'h5, lastCyc + 2);
    pushExp(4'h5, lastCyc + 3);
    for (int i = 0; i < nData; i++) begin
      n = 4'($urandom % 16);
      sendGroup(enc5(n));
      pushExp(n, lastCyc + 2);
    end
    case (endKind)
      0: begin sendGroup(5'b01101); sendGroup(5'b00111); expErr = 0; endReq = "R6"; end
      1: begin sendGroup(5'b11111); expErr = 1; endReq = "R7"; end
      2: begin
        bad = 5'($urandom);
        while (isKnown(bad)) bad = 5'($urandom);
        sendGroup(bad);
        expErr = 1; endReq = "R8";
      end
      default: begin
        sendGroup(5'b01101);
        sendGroup(enc5(4'($urandom % 16)));
        expErr = 1; endReq = "R8";
      end
    endcase
    endCyc = lastCyc + 2;
    sendIdle(postIdle);
    @(posedge clk);
    #1;
    check(nLog == nExp, "R5 nibble count", nLog, nExp);
    for (int i = 0; i < nExp && i < nLog; i++) begin
      check(logNib[i] == expNib[i], (i < 2) ? "R3 preamble value" : "R5 decoded value",
            int'(logNib[i]), int'(expNib[i]));
      check(logCyc[i] == expCyc[i], (i < 2) ? "R3 preamble timing" : "R5 nibble timing",
            logCyc[i], expCyc[i]);
    end
    check(riseCnt == 1 && fallCnt == 1, "R9 one continuous valid", riseCnt * 10 + fallCnt, 11);
    check(stbNoDv == 0, "R9 strobe without valid", stbNoDv, 0);
    check(fallCyc == endCyc, endReq, fallCyc, endCyc);
    check(errCnt == int'(expErr), endReq, errCnt, int'(expErr));
    if (expErr) check(errCyc == endCyc, endReq, errCyc, endCyc);
    check(fcCnt == 0, "R4 no false carrier in frame", fcCnt, 0);
  endtask

  initial begin
    int seedSink;
    seedSink = $urandom(32'h5EED_0042);
    monOn = 1'b1;
    prevDv = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(rxDv == 0 && rxStb == 0 && rxErr == 0 && falseCarrier == 0 && rxData == 0,
          "R1 in reset", {rxDv, rxStb, rxErr, falseCarrier}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(rxDv == 0 && rxStb == 0 && rxErr == 0 && falseCarrier == 0 && rxData == 0,
          "R1 after reset", {rxDv, rxStb, rxErr, falseCarrier}, 0);

    // R2 isolated zero and a run of adjacent zeros
    clearLog();
    sendIdle(12); sendBit(0); sendIdle(12);
    sendBit(0); sendBit(0); sendBit(0); sendIdle(12);
    @(posedge clk); #1;
    check(nLog == 0 && riseCnt == 0, "R2 noise no frame", nLog + riseCnt, 0);
    check(fcCnt == 0 && errCnt == 0, "R2 noise no flags", fcCnt + errCnt, 0);

    // R4 broken window, then /J/ with corrupted /K/
    clearLog();
    sendIdle(12); sendBit(1); sendBit(1); sendBit(0); sendBit(1); sendBit(0);
    sendIdle(15);
    @(posedge clk); #1;
    check(fcCnt == 1, "R4 false carrier pulse", fcCnt, 1);
    check(riseCnt == 0 && nLog == 0, "R4 no valid on false carrier", riseCnt + nLog, 0);
    clearLog();
    sendIdle(12); sendGroup(5'b11000); sendGroup(5'b10011); sendIdle(15);
    @(posedge clk); #1;
    check(fcCnt == 1, "R4 corrupted K", fcCnt, 1);
    check(riseCnt == 0, "R4 corrupted K no valid", riseCnt, 0);

    // directed endings
    runFrame(3, 0, 12, 15);
    runFrame(0, 0, 12, 15);
    runFrame(2, 1, 12, 15);
    runFrame(4, 3, 12, 15);
    runFrame(1, 2, 12, 15);

    // R10 frame right after a /T/R/ end with no extra idle
    runFrame(5, 0, 12, 3);
    runFrame(4, 0, 0, 15);
    check(fcCnt == 0, "R10 no carrier from leftover bits", fcCnt, 0);

    // random frames
    for (int f = 0; f < 40; f++) begin
      runFrame(int'($urandom_range(0, 20)), int'($urandom % 4), 12, 15);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule